// File: doc/BRIEF.md
# Urgency-Driven Thread Switch Controller

This block decides when a two-context, coarse-grained multithreaded in-order core hands its pipeline from the running (foreground) thread to the waiting (background) thread. Each context carries a 3-bit urgency score. Per-thread event strobes move that score. A miss on a long-latency memory access lowers it. A returning miss raises it back, but never above the nominal level. An external interrupt and an expired fairness timer push it up to fixed high levels.

The controller compares the two scores every cycle. A switch starts when the foreground score is strictly below the background score, or when the foreground software issues a switch hint. A switch is a two-step sequence. First a one-cycle flush request goes to the pipeline. On the next cycle the active context changes and a switch pulse marks the change. A programmable hold-off window then blocks any further switch, so the two threads cannot thrash.

The fairness timer counts the cycles the background thread has waited and fires at a programmable limit. Both current urgency scores are visible on outputs.

Top module: `cgmt_switch_ctrl`

## Requirements
- R1: After reset, thread 0 is active, both urgency outputs read 5, and flush and switch outputs are low.
- R2: A miss strobe for a thread lowers its urgency by one at the next clock edge; at 0 it stays 0.
- R3: A fill (miss data returned) strobe raises the thread's urgency by one if it is below 5 and leaves it unchanged if it is 5 or more.
- R4: An interrupt strobe sets the thread's urgency to 6. When several events hit one thread in the same cycle the order of precedence is: becoming foreground (5), timeout (7), interrupt (6), miss, fill.
- R5: A wait counter for the background thread counts every cycle. It is cleared when the threads swap. When a non-zero limit is set and the count has reached it, the background urgency becomes 7 and the count restarts. A limit of 0 disables the timeout.
- R6: If no flush is pending and the hold-off window is empty, then a foreground urgency strictly below the background urgency, or a hint strobe, raises flush for exactly one cycle starting at the next edge.
- R7: In the cycle after flush, the active thread ID has toggled and the switch output is high for one cycle. The new foreground thread's urgency reads 5. The active ID never changes without a flush in the cycle before.
- R8: After a swap, no new flush can begin for the programmed hold-off number of cycles. A hint strobe that arrives in that window is dropped and is not remembered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| miss_i | input | 2 | Per-thread long-latency miss strobe |
| fill_i | input | 2 | Per-thread miss-data-returned strobe |
| irq_i | input | 2 | Per-thread external interrupt strobe |
| hint_i | input | 1 | Software switch hint from the foreground thread |
| wait_limit_i | input | CNT_W | Background wait limit in cycles, 0 disables |
| holdoff_i | input | HOLD_W | Cycles in which no new switch is allowed after a swap |
| active_o | output | 1 | ID of the foreground thread |
| switch_o | output | 1 | One-cycle pulse in the first cycle under the new thread |
| flush_o | output | 1 | One-cycle pipeline flush request |
| urg0_o | output | 3 | Urgency of thread 0 |
| urg1_o | output | 3 | Urgency of thread 1 |

## Verification
The bound checker watches the switch handshake on every cycle. It checks that flush lasts one cycle and is always followed by a toggle and a switch pulse. It checks that the active ID never moves without a flush, that a new foreground thread starts at the nominal level, that every flush has a cause, and that no flush falls inside the hold-off window. The arithmetic of the urgency scores can only be shown by the bench's scenarios. These cover saturation at 0 and 5, the precedence among events that land in the same cycle, the timeout firing or staying silent for a given limit, and a hint being dropped. A long random sweep is also compared against a cycle model written from the requirements.

// File: rtl/cgmt_switch_ctrl.sv
module cgmt_switch_ctrl #(
  parameter int CNT_W  = 16,
  parameter int HOLD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        miss_i,
  input  logic [1:0]        fill_i,
  input  logic [1:0]        irq_i,
  input  logic              hint_i,
  input  logic [CNT_W-1:0]  wait_limit_i,
  input  logic [HOLD_W-1:0] holdoff_i,
  output logic              active_o,
  output logic              switch_o,
  output logic              flush_o,
  output logic [2:0]        urg0_o,
  output logic [2:0]        urg1_o
);
  localparam logic [2:0] U_NOM = 3'd5;
  localparam logic [2:0] U_IRQ = 3'd6;
  localparam logic [2:0] U_TMO = 3'd7;

  logic [2:0]        urg_q [2];
  logic [2:0]        urg_d [2];
  logic              act_q, flush_q, sw_q, bg, go, fire;
  logic [HOLD_W-1:0] hold_q;
  logic [CNT_W-1:0]  wait_q;
  logic [2:0]        u_fg, u_bg;

  assign bg   = ~act_q;
  assign u_fg = act_q ? urg_q[1] : urg_q[0];
  assign u_bg = act_q ? urg_q[0] : urg_q[1];
  assign go   = !flush_q && (hold_q == '0) && (hint_i || (u_fg < u_bg));
  assign fire = (wait_limit_i != '0) && (wait_q >= wait_limit_i) && !flush_q;

  always_comb begin
    for (int t = 0; t < 2; t++) begin
      if (flush_q && (1'(t) == bg))      urg_d[t] = U_NOM;
      else if (fire && (1'(t) == bg))    urg_d[t] = U_TMO;
      else if (irq_i[t])                 urg_d[t] = U_IRQ;
      else if (miss_i[t])                urg_d[t] = (urg_q[t] == 3'd0) ? 3'd0 : urg_q[t] - 3'd1;
      else if (fill_i[t])                urg_d[t] = (urg_q[t] < U_NOM) ? urg_q[t] + 3'd1 : urg_q[t];
      else                               urg_d[t] = urg_q[t];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      urg_q[0] <= U_NOM;
      urg_q[1] <= U_NOM;
      act_q    <= 1'b0;
      flush_q  <= 1'b0;
      sw_q     <= 1'b0;
      hold_q   <= '0;
      wait_q   <= '0;
    end else begin
      urg_q[0] <= urg_d[0];
      urg_q[1] <= urg_d[1];
      flush_q  <= go;
      sw_q     <= flush_q;
      if (flush_q) act_q <= ~act_q;

      if (flush_q)              hold_q <= holdoff_i;
      else if (hold_q != '0)    hold_q <= hold_q - 1'b1;

      if (flush_q || fire)      wait_q <= '0;
      else if ((wait_limit_i != '0) && (wait_q != '1)) wait_q <= wait_q + 1'b1;
    end
  end

  assign active_o = act_q;
  assign switch_o = sw_q;
  assign flush_o  = flush_q;
  assign urg0_o   = urg_q[0];
  assign urg1_o   = urg_q[1];
endmodule

module cgmt_switch_ctrl_chk #(
  parameter int HOLD_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              hint_i,
  input logic [HOLD_W-1:0] holdoff_i,
  input logic              active_o,
  input logic              switch_o,
  input logic              flush_o,
  input logic [2:0]        urg0_o,
  input logic [2:0]        urg1_o
);
  logic [HOLD_W-1:0] win;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            win <= '0;
    else if (flush_o)      win <= holdoff_i;
    else if (win != '0)    win <= win - 1'b1;
  end

  assert_flush_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    flush_o |=> !flush_o);
  assert_flush_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flush_o) |-> $past(hint_i || (active_o ? (urg1_o < urg0_o) : (urg0_o < urg1_o))));
  assert_swap_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flush_o |=> (switch_o && (active_o != $past(active_o))));
  assert_no_stray_swap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !flush_o |=> ($stable(active_o) && !switch_o));
  assert_newfg_nominal_R7: assert property (@(posedge clk) disable iff (!rst_n)
    switch_o |-> ((active_o ? urg1_o : urg0_o) == 3'd5));
  assert_holdoff_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (win != '0) |=> !flush_o);
endmodule

bind cgmt_switch_ctrl cgmt_switch_ctrl_chk #(.HOLD_W(HOLD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .hint_i(hint_i), .holdoff_i(holdoff_i),
  .active_o(active_o), .switch_o(switch_o), .flush_o(flush_o),
  .urg0_o(urg0_o), .urg1_o(urg1_o));

// File: tb/tb_cgmt_switch_ctrl.sv
module tb_cgmt_switch_ctrl;
  localparam int CNT_W = 16;
  localparam int HOLD_W = 8;

  logic clk = 0, rst_n = 0;
  logic [1:0] miss_i = 0, fill_i = 0, irq_i = 0;
  logic hint_i = 0;
  logic [CNT_W-1:0] wait_limit_i = 0;
  logic [HOLD_W-1:0] holdoff_i = 3;
  logic active_o, switch_o, flush_o;
  logic [2:0] urg0_o, urg1_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  cgmt_switch_ctrl #(.CNT_W(CNT_W), .HOLD_W(HOLD_W)) dut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // cycle model built from the requirements
  int m_u[2], m_act, m_fl, m_sw, m_hold, m_wait;
  function automatic int nxt(int cur, bit to_fg, bit tmo, bit irq, bit miss, bit fill);
    if (to_fg) return 5;
    if (tmo) return 7;
    if (irq) return 6;
    if (miss) return (cur == 0) ? 0 : cur - 1;
    if (fill) return (cur < 5) ? cur + 1 : cur;
    return cur;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_u[0] = 5; m_u[1] = 5; m_act = 0; m_fl = 0; m_sw = 0; m_hold = 0; m_wait = 0;
    end else begin
      int fgu, bgu, b, lim;
      bit go, fire;
      b = 1 - m_act;
      fgu = m_u[m_act];
      bgu = m_u[b];
      lim = int'(wait_limit_i);
      go = (m_fl == 0) && (m_hold == 0) && (hint_i || fgu < bgu);
      fire = (lim != 0) && (m_wait >= lim) && (m_fl == 0);
      for (int t = 0; t < 2; t++)
        m_u[t] = nxt(m_u[t], m_fl != 0 && t == b, fire && t == b, irq_i[t], miss_i[t], fill_i[t]);
      if (m_fl != 0) m_hold = int'(holdoff_i);
      else if (m_hold != 0) m_hold--;
      if (m_fl != 0 || fire) m_wait = 0;
      else if (lim != 0 && m_wait < 65535) m_wait++;
      m_sw = m_fl;
      if (m_fl != 0) m_act = b;
      m_fl = go ? 1 : 0;
    end
  end

  always @(negedge clk) if (rst_n && !done) begin
    chk(int'(active_o) == m_act, "R7 model active", int'(active_o), m_act);
    chk(int'(flush_o) == m_fl, "R6 model flush", int'(flush_o), m_fl);
    chk(int'(switch_o) == m_sw, "R7 model switch", int'(switch_o), m_sw);
    chk(int'(urg0_o) == m_u[0], "R2/R3/R4/R5 model urg0", int'(urg0_o), m_u[0]);
    chk(int'(urg1_o) == m_u[1], "R2/R3/R4/R5 model urg1", int'(urg1_o), m_u[1]);
  end

  task automatic pulse(input logic [1:0] m, input logic [1:0] f, input logic [1:0] q, input logic h);
    @(negedge clk);
    miss_i = m; fill_i = f; irq_i = q; hint_i = h;
    @(negedge clk);
    miss_i = 0; fill_i = 0; irq_i = 0; hint_i = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(4 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    bit seen;
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk(active_o == 0 && flush_o == 0 && switch_o == 0, "R1 reset ctrl", {active_o, flush_o, switch_o}, 0);
    chk(urg0_o == 5 && urg1_o == 5, "R1 reset urgency", {urg0_o, urg1_o}, 8'o55);

    for (int i = 0; i < 7; i++) pulse(2'b10, 0, 0, 0);
    chk(urg1_o == 0, "R2 miss saturates at 0", urg1_o, 0);
    chk(active_o == 0, "R2 no switch for lower bg", active_o, 0);

    for (int i = 0; i < 6; i++) pulse(0, 2'b10, 0, 0);
    chk(urg1_o == 5, "R3 fill caps at 5", urg1_o, 5);

    pulse(0, 0, 2'b10, 0);
    chk(urg1_o == 6 && flush_o == 0, "R4 irq sets 6", urg1_o, 6);
    @(negedge clk);
    chk(flush_o == 1 && active_o == 0, "R6 flush after urgency cross", flush_o, 1);
    @(negedge clk);
    chk(active_o == 1 && switch_o == 1 && flush_o == 0, "R7 swap after flush", {active_o, switch_o, flush_o}, 3'b110);
    chk(urg1_o == 5, "R7 new fg nominal", urg1_o, 5);

    hint_i = 1; @(negedge clk); hint_i = 0;
    seen = 0;
    for (int i = 0; i < 8; i++) begin
      if (flush_o) seen = 1;
      @(negedge clk);
    end
    chk(!seen && active_o == 1, "R8 hint in hold-off dropped", seen, 0);

    pulse(0, 0, 0, 1);
    chk(flush_o == 1, "R6 hint forces flush", flush_o, 1);
    @(negedge clk);
    chk(active_o == 0 && switch_o == 1, "R7 hint swap", active_o, 0);
    idle(5);

    pulse(2'b10, 0, 2'b10, 0);
    chk(urg1_o == 6, "R4 irq beats miss", urg1_o, 6);
    idle(6);
    chk(active_o == 1, "R6 switch to thread 1", active_o, 1);
    pulse(2'b01, 2'b01, 0, 0);
    chk(urg0_o == 4, "R4 miss beats fill", urg0_o, 4);

    idle(20);
    chk(urg0_o == 4 && active_o == 1, "R5 limit 0 no timeout", urg0_o, 4);
    wait_limit_i = 6;
    seen = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (urg0_o == 7) seen = 1;
    end
    chk(seen, "R5 timeout raises bg to 7", urg0_o, 7);
    idle(4);
    chk(active_o == 0, "R5 timeout leads to switch", active_o, 0);

    for (int blk = 0; blk < 4; blk++) begin
      wait_limit_i = (blk == 0) ? 16'd0 : (blk == 1) ? 16'd5 : 16'd13;
      holdoff_i = (blk == 3) ? 8'd0 : 8'd2;
      for (int c = 0; c < 1000; c++) begin
        @(negedge clk);
        miss_i = {($urandom % 8 == 0), ($urandom % 8 == 0)};
        fill_i = {($urandom % 6 == 0), ($urandom % 6 == 0)};
        irq_i  = {($urandom % 40 == 0), ($urandom % 40 == 0)};
        hint_i = ($urandom % 30 == 0);
      end
    end
    @(negedge clk);
    miss_i = 0; fill_i = 0; irq_i = 0; hint_i = 0;
    idle(4);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule